// File: doc/BRIEF.md
# One-Bit Cascadable Datapath Slice

A tile that is exactly one bit wide and carries its own eight register bits, two read multiplexers and a small ALU. Each result bit comes from one eight-way selection. Identical tiles placed side by side form a register file and ALU of any width. Carry ripples from tile to tile, and each tile's first operand bit is offered to both neighbours so that single-step shifts need no extra wiring.

In one clock cycle every tile reads two registers, forms one result bit and writes that bit into a third register. The top module chains `WIDTH` tiles. It ties the unused shift inputs at both ends to zero. It drives the low carry-in from the operation: 1 for subtract, 0 otherwise.

All pins are plain control and data levels sampled on the rising clock edge. There is no handshake and no back-pressure: one operation completes every cycle.

Top module: `bslice_chain`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers in every tile to 0 at the next rising edge.
- R2: `opnd_a` and `opnd_b` show, in the same cycle and independently, the registers chosen by `rd_a_sel` and `rd_b_sel`. Any pair may be chosen, including the same register twice.
- R3: When `wr_en` is 1, the register chosen by `wr_sel` loads `result` at the rising edge. All other registers keep their values.
- R4: When `wr_en` is 0, no register changes at the edge, whatever the other inputs are.
- R5: Opcode 3'b000 (add) gives `result` = (A + B) mod 2^WIDTH, and `carry_out` is the carry from the top bit.
- R6: Opcode 3'b001 (subtract) gives `result` = (A − B) mod 2^WIDTH, and `carry_out` is 1 exactly when A ≥ B unsigned.
- R7: Opcodes 3'b010, 3'b011 and 3'b100 give the bitwise AND, OR and XOR of A and B.
- R8: Opcode 3'b101 gives A shifted one place toward the top bit, with 0 entering bit 0.
- R9: Opcode 3'b110 gives A shifted one place toward bit 0, with 0 entering the top bit.
- R10: Opcode 3'b111 gives `result` = `ext_data`.
- R11: `carry_out` is 0 for opcodes 3'b010 to 3'b111.
- R12: The destination may equal a source. The stored value is then computed from the values the sources held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| rd_a_sel | input | 3 | Register read as operand A |
| rd_b_sel | input | 3 | Register read as operand B |
| wr_sel | input | 3 | Destination register |
| wr_en | input | 1 | Write enable for the destination |
| op | input | 3 | Operation code (see R5–R10) |
| ext_data | input | WIDTH | External word for the pass operation |
| opnd_a | output | WIDTH | Operand A word |
| opnd_b | output | WIDTH | Operand B word |
| result | output | WIDTH | ALU result word |
| carry_out | output | 1 | Carry from the top tile |

## Verification
The assertions take for granted that every input is a known 0 or 1 once reset has been released. They also assume inputs change only away from the rising edge, so that the operands, opcode and result seen at an edge belong to a single operation. The stimulus sets every select, enable, opcode and data bit on the falling edge of each cycle, before any check is made. It holds reset from time zero until it has run for several edges.

// File: rtl/bslice_pkg.sv
package bslice_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SHL  = 3'd5,
    OP_SHR  = 3'd6,
    OP_PASS = 3'd7
  } alu_op_e;

  localparam int unsigned OP_W = 3;
endpackage

// File: rtl/bslice_regs.sv
module bslice_regs #(
  parameter int unsigned NREGS = 8,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_a_sel,
  input  logic [SEL_W-1:0] rd_b_sel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_en,
  input  logic             wr_bit,
  output logic             rd_a_bit,
  output logic             rd_b_bit
);
  logic [NREGS-1:0] bits;
  logic [NREGS-1:0] wr_hot;

  // write decoder with enable
  always_comb begin
    wr_hot = '0;
    if (wr_en) wr_hot[wr_sel] = 1'b1;
  end

  // one storage bit per register, each fed by a 2:1 select
  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    logic d_next;
    assign d_next = wr_hot[g] ? wr_bit : bits[g];

    always_ff @(posedge clk) begin
      if (rst) bits[g] <= 1'b0;
      else     bits[g] <= d_next;
    end

    AST_LOAD_PICKED: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_sel == SEL_W'(g)) |=> bits[g] == $past(wr_bit)); // R3
    AST_HOLD_OTHERS: assert property (@(posedge clk) disable iff (rst)
      (!wr_en || wr_sel != SEL_W'(g)) |=> $stable(bits[g])); // R4
  end

  // two independent read selects
  assign rd_a_bit = bits[rd_a_sel];
  assign rd_b_bit = bits[rd_b_sel];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> bits == '0); // R1
endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
  import bslice_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            a,
  input  logic            b,
  input  logic            cin,
  input  logic            from_lower,
  input  logic            from_upper,
  input  logic            ext_bit,
  output logic            res,
  output logic            cout
);
  alu_op_e opc;
  logic    b_eff;
  logic    sum;
  logic    maj;

  always_comb begin
    opc   = alu_op_e'(op);
    b_eff = (opc == OP_SUB) ? ~b : b;
    sum   = a ^ b_eff ^ cin;
    maj   = (a & b_eff) | (a & cin) | (b_eff & cin);
  end

  // single eight-way result select
  always_comb begin
    cout = 1'b0;
    unique case (opc)
      OP_ADD, OP_SUB: begin res = sum; cout = maj; end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SHL:  res = from_lower;
      OP_SHR:  res = from_upper;
      OP_PASS: res = ext_bit;
      default: res = 1'b0;
    endcase
  end
endmodule

// File: rtl/bslice_tile.sv
module bslice_tile
  import bslice_pkg::*;
#(
  parameter int unsigned NREGS = 8,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_a_sel,
  input  logic [SEL_W-1:0] rd_b_sel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_en,
  input  logic [OP_W-1:0]  op,
  input  logic             carry_in,
  input  logic             from_lower,
  input  logic             from_upper,
  input  logic             ext_bit,
  output logic             carry_out,
  output logic             a_bit,
  output logic             b_bit,
  output logic             res_bit
);
  bslice_regs #(.NREGS(NREGS)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_a_sel (rd_a_sel),
    .rd_b_sel (rd_b_sel),
    .wr_sel   (wr_sel),
    .wr_en    (wr_en),
    .wr_bit   (res_bit),
    .rd_a_bit (a_bit),
    .rd_b_bit (b_bit)
  );

  bslice_alu u_alu (
    .op         (op),
    .a          (a_bit),
    .b          (b_bit),
    .cin        (carry_in),
    .from_lower (from_lower),
    .from_upper (from_upper),
    .ext_bit    (ext_bit),
    .res        (res_bit),
    .cout       (carry_out)
  );

  AST_CARRY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (op >= 3'd2) |-> !carry_out); // R11
  AST_PASS_EXT: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd7) |-> res_bit == ext_bit); // R10
endmodule

// File: rtl/bslice_chain.sv
module bslice_chain
  import bslice_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned NREGS = 8,
  localparam int unsigned SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rd_a_sel,
  input  logic [SEL_W-1:0] rd_b_sel,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_en,
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] ext_data,
  output logic [WIDTH-1:0] opnd_a,
  output logic [WIDTH-1:0] opnd_b,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic [WIDTH:0] carry;

  // subtract enters the low tile with carry set (two's complement)
  assign carry[0]  = (alu_op_e'(op) == OP_SUB);
  assign carry_out = carry[WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_tile
    logic lo_in;
    logic hi_in;

    if (i == 0) begin : g_lo_end
      assign lo_in = 1'b0;
    end else begin : g_lo_link
      assign lo_in = opnd_a[i-1];
    end

    if (i == WIDTH - 1) begin : g_hi_end
      assign hi_in = 1'b0;
    end else begin : g_hi_link
      assign hi_in = opnd_a[i+1];
    end

    bslice_tile #(.NREGS(NREGS)) u_tile (
      .clk        (clk),
      .rst        (rst),
      .rd_a_sel   (rd_a_sel),
      .rd_b_sel   (rd_b_sel),
      .wr_sel     (wr_sel),
      .wr_en      (wr_en),
      .op         (op),
      .carry_in   (carry[i]),
      .from_lower (lo_in),
      .from_upper (hi_in),
      .ext_bit    (ext_data[i]),
      .carry_out  (carry[i+1]),
      .a_bit      (opnd_a[i]),
      .b_bit      (opnd_b[i]),
      .res_bit    (result[i])
    );
  end

  AST_ADD_WORD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0) |-> {carry_out, result} == ({1'b0, opnd_a} + {1'b0, opnd_b})); // R5
  AST_SUB_WORD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd1) |-> (result == opnd_a - opnd_b) && (carry_out == (opnd_a >= opnd_b))); // R6
  AST_XOR_WORD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd4) |-> result == (opnd_a ^ opnd_b)); // R7
  AST_SHL_WORD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd5) |-> result == {opnd_a[WIDTH-2:0], 1'b0}); // R8
  AST_SHR_WORD: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd6) |-> result == {1'b0, opnd_a[WIDTH-1:1]}); // R9
endmodule

// File: tb/tb_bslice_chain.sv
module tb_bslice_chain;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   ra = '0, rb = '0, wd = '0, op = '0;
  logic         we = 1'b0;
  logic [W-1:0] ext = '0;
  logic [W-1:0] opnd_a, opnd_b, result;
  logic         carry_out;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] mreg [8];

  always #5 clk = ~clk;

  bslice_chain #(.WIDTH(W), .NREGS(8)) dut (
    .clk(clk), .rst(rst), .rd_a_sel(ra), .rd_b_sel(rb), .wr_sel(wd),
    .wr_en(we), .op(op), .ext_data(ext), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .carry_out(carry_out)
  );

  // fields: op ra rb wd we ext expected_result expected_carry
  localparam logic [29:0] TBL [12] = '{
    {3'd7, 3'd0, 3'd0, 3'd1, 1'b1, 8'h5A, 8'h5A, 1'b0}, // R10
    {3'd7, 3'd0, 3'd0, 3'd2, 1'b1, 8'hC3, 8'hC3, 1'b0}, // R10
    {3'd0, 3'd1, 3'd2, 3'd3, 1'b1, 8'h00, 8'h1D, 1'b1}, // R5
    {3'd1, 3'd1, 3'd2, 3'd4, 1'b1, 8'h00, 8'h97, 1'b0}, // R6 borrow
    {3'd1, 3'd2, 3'd1, 3'd5, 1'b1, 8'h00, 8'h69, 1'b1}, // R6
    {3'd2, 3'd1, 3'd2, 3'd6, 1'b1, 8'h00, 8'h42, 1'b0}, // R7
    {3'd3, 3'd1, 3'd2, 3'd7, 1'b1, 8'h00, 8'hDB, 1'b0}, // R7
    {3'd4, 3'd1, 3'd2, 3'd0, 1'b1, 8'h00, 8'h99, 1'b0}, // R7
    {3'd5, 3'd2, 3'd0, 3'd2, 1'b1, 8'h00, 8'h86, 1'b0}, // R8 R12
    {3'd6, 3'd2, 3'd0, 3'd2, 1'b1, 8'h00, 8'h43, 1'b0}, // R9 R12
    {3'd0, 3'd3, 3'd2, 3'd1, 1'b0, 8'h00, 8'h60, 1'b0}, // R4
    {3'd4, 3'd1, 3'd1, 3'd1, 1'b1, 8'h00, 8'h00, 1'b0}  // R12
  };

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [2:0] a, input logic [2:0] b,
                       input logic [2:0] d, input logic e, input logic [W-1:0] x);
    @(negedge clk);
    op = o; ra = a; rb = b; wd = d; we = e; ext = x;
    #2;
  endtask

  function automatic logic [W:0] model(input logic [2:0] o, input logic [W-1:0] a,
                                       input logic [W-1:0] b, input logic [W-1:0] x);
    case (o)
      3'd0: model = {1'b0, a} + {1'b0, b};
      3'd1: model = {1'b0, a} + {1'b0, ~b} + 9'd1;
      3'd2: model = {1'b0, a & b};
      3'd3: model = {1'b0, a | b};
      3'd4: model = {1'b0, a ^ b};
      3'd5: model = {1'b0, a[W-2:0], 1'b0};
      3'd6: model = {2'b0, a[W-1:1]};
      default: model = {1'b0, x};
    endcase
  endfunction

  task automatic sweep_zero(input string req);
    for (int r = 0; r < 8; r++) begin
      drive(3'd0, 3'(r), 3'(7 - r), 3'd0, 1'b0, '0);
      check(req, {1'b0, opnd_a}, '0);
      check(req, {1'b0, opnd_b}, '0);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    sweep_zero("R1");
    for (int k = 0; k < 8; k++) mreg[k] = '0;

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic [29:0] v;
      v = TBL[i];
      drive(v[29:27], v[26:24], v[23:21], v[20:18], v[17], v[16:9]);
      check("R2", {1'b0, opnd_a}, {1'b0, mreg[v[26:24]]});
      check("R5-7 table", {carry_out, result}, {v[0], v[8:1]});
      if (v[17]) mreg[v[20:18]] = v[8:1];
    end
    drive(3'd7, 3'd1, 3'd0, 3'd0, 1'b0, 8'hFF);
    check("R12", {1'b0, opnd_a}, 9'h000);

    // R4: write disabled must leave target untouched
    drive(3'd7, 3'd0, 3'd0, 3'd5, 1'b0, 8'hEE);
    drive(3'd0, 3'd5, 3'd5, 3'd0, 1'b0, '0);
    check("R4", {1'b0, opnd_a}, {1'b0, mreg[5]});

    // random operations against the model
    for (int n = 0; n < 400; n++) begin
      logic [2:0] o, a, b, d;
      logic e;
      logic [W-1:0] x;
      o = 3'($urandom); a = 3'($urandom); b = 3'($urandom);
      d = 3'($urandom); e = 1'($urandom); x = 8'($urandom);
      if (n < 16) o = 3'd7;
      drive(o, a, b, d, e, x);
      check("R2", {1'b0, opnd_a}, {1'b0, mreg[a]});
      check("R2", {1'b0, opnd_b}, {1'b0, mreg[b]});
      check("R5-R11", {carry_out, result}, model(o, mreg[a], mreg[b], x));
      if (e) mreg[d] = model(o, mreg[a], mreg[b], x)[W-1:0];
    end

    // corners: add overflow, subtract equal, R11 for pass with all ones
    drive(3'd7, 3'd0, 3'd0, 3'd0, 1'b1, 8'hFF);
    drive(3'd7, 3'd0, 3'd0, 3'd1, 1'b1, 8'h01);
    drive(3'd0, 3'd0, 3'd1, 3'd2, 1'b0, '0);
    check("R5", {carry_out, result}, 9'h100);
    drive(3'd1, 3'd0, 3'd0, 3'd2, 1'b0, '0);
    check("R6", {carry_out, result}, 9'h100);
    drive(3'd1, 3'd1, 3'd0, 3'd2, 1'b0, '0);
    check("R6", {carry_out, result}, 9'h002);
    drive(3'd7, 3'd0, 3'd0, 3'd2, 1'b0, 8'hFF);
    check("R11", {carry_out, result}, 9'h0FF);
    drive(3'd5, 3'd0, 3'd0, 3'd2, 1'b0, '0);
    check("R8", {carry_out, result}, 9'h0FE);
    drive(3'd6, 3'd0, 3'd0, 3'd2, 1'b0, '0);
    check("R9", {carry_out, result}, 9'h07F);

    // mid-run reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    sweep_zero("R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule